// File: doc/BRIEF.md
# Multithreaded Register Rename Table

This block maps architectural register operands to physical register tags for a core that runs several hardware threads at once. Each thread has its own architectural namespace, so register 3 of one thread and register 3 of another are unrelated. Both resolve into one physical register file that all threads share. Each table is indexed by the thread number joined with the register number. Because of this, the physical tags that come out are unique across threads, and a shared scheduler downstream needs no thread field to keep them apart.

Each thread holds two maps: a speculative map that renaming reads and updates, and a committed map that retirement updates. One free pool of physical registers serves every thread. A rename request looks up two sources and the old destination mapping, and it claims a fresh tag for the destination. The lookup and the allocation are combinational and take effect at the next clock edge. A commit on a thread's port moves the committed map forward and frees the mapping it replaces. A flush on a thread's port copies that thread's committed map over its speculative map and frees the tags the thread claimed since its last commit.

Top module: `mt_rename_top`

## Requirements
- R1: After reset, register a of thread t maps to physical tag t*NA+a in both maps, and tags NT*NA to NP-1 are free.
- R2: A rename in one thread changes no mapping that another thread sees.
- R3: A granted rename returns as dst_tag_o the lowest-numbered free tag and removes it from the pool. Later source lookups of that register in the same thread return the new tag.
- R4: old_tag_o is the speculative mapping of the destination register as it was before the rename.
- R5: A source that names the destination register of the same request reads the mapping from before the rename.
- R6: ren_ready_o is low when the pool is empty, or when the requesting thread's flush is asserted in that cycle. A request made while ren_ready_o is low allocates nothing and changes no map.
- R7: A commit on thread t of register a with tag p sets the committed mapping to p, and the tag previously committed for a returns to the pool.
- R8: A flush of thread t sets every speculative mapping of t to its committed mapping and leaves other threads untouched.
- R9: A flush of thread t returns to the pool every tag that t allocated and that has not yet been committed.
- R10: When a commit and a flush of the same thread fall in one cycle, the flush restores the committed map that already includes that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| ren_tid_i | input | TID_W | Thread of the request |
| ren_src0_i | input | AREG_W | First source register |
| ren_src1_i | input | AREG_W | Second source register |
| ren_dst_i | input | AREG_W | Destination register |
| ren_ready_o | output | 1 | Request will be granted this cycle |
| src0_tag_o | output | PREG_W | Physical tag of first source |
| src1_tag_o | output | PREG_W | Physical tag of second source |
| dst_tag_o | output | PREG_W | Newly allocated destination tag |
| old_tag_o | output | PREG_W | Previous destination mapping |
| cmt_valid_i | input | NT | Per-thread commit strobe |
| cmt_areg_i | input | NT x AREG_W | Per-thread committed register |
| cmt_tag_i | input | NT x PREG_W | Per-thread committed tag |
| flush_i | input | NT | Per-thread flush |

## Verification
Two functions can act on the pool and the maps in the same cycle. A rename can be granted while a commit or a flush releases tags, and a flush can land on the thread that is renaming. The bench provokes these by driving a rename together with a commit on one thread and a flush on the other. It also drives a commit and a flush on the same thread together, and a rename aimed at a thread that is being flushed. A reference model applies the commits first, then the flushes, then the rename, and computes from the state before the cycle both the grant and the tag of the next allocation. Each granted tag and each later lookup is then compared against that model.

// File: rtl/mt_rename_pkg.sv
package mt_rename_pkg;
  parameter int unsigned RN_THREADS = 2;
  parameter int unsigned RN_AREGS   = 8;
  parameter int unsigned RN_PREGS   = 32;
endpackage

// File: rtl/mt_free_list.sv
module mt_free_list #(
  parameter int unsigned NP     = 32,
  parameter int unsigned NRES   = 16,
  localparam int unsigned PREG_W = $clog2(NP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  output logic              avail_o,
  output logic [PREG_W-1:0] alloc_tag_o,
  input  logic [NP-1:0]     release_i,
  output logic [NP-1:0]     free_o
);
  logic [NP-1:0] free_q, free_d, take;

  // lowest free index wins
  always_comb begin
    alloc_tag_o = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_tag_o = PREG_W'(i);
    end
  end

  assign avail_o = |free_q;
  assign take    = (alloc_i && avail_o) ? (NP'(1) << alloc_tag_o) : '0;
  assign free_d  = (free_q & ~take) | release_i;
  assign free_o  = free_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= NRES);
    end else begin
      free_q <= free_d;
    end
  end
endmodule

// File: rtl/mt_map_table.sv
module mt_map_table #(
  parameter int unsigned NT = 2,
  parameter int unsigned NA = 8,
  parameter int unsigned NP = 32,
  localparam int unsigned TID_W  = $clog2(NT),
  localparam int unsigned AREG_W = $clog2(NA),
  localparam int unsigned PREG_W = $clog2(NP),
  localparam int unsigned IDX_W  = TID_W + AREG_W,
  localparam int unsigned NE     = NT * NA
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             rd0_idx_i,
  input  logic [IDX_W-1:0]             rd1_idx_i,
  input  logic [IDX_W-1:0]             rdd_idx_i,
  output logic [PREG_W-1:0]            rd0_tag_o,
  output logic [PREG_W-1:0]            rd1_tag_o,
  output logic [PREG_W-1:0]            rdd_tag_o,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [PREG_W-1:0]            wr_tag_i,
  input  logic [NT-1:0]                cmt_en_i,
  input  logic [NT-1:0][AREG_W-1:0]    cmt_areg_i,
  input  logic [NT-1:0][PREG_W-1:0]    cmt_tag_i,
  output logic [NT-1:0][PREG_W-1:0]    cmt_old_o,
  input  logic [NT-1:0]                flush_i
);
  logic [PREG_W-1:0] spec_q [NE];
  logic [PREG_W-1:0] spec_d [NE];
  logic [PREG_W-1:0] arch_q [NE];
  logic [PREG_W-1:0] arch_d [NE];

  assign rd0_tag_o = spec_q[rd0_idx_i];
  assign rd1_tag_o = spec_q[rd1_idx_i];
  assign rdd_tag_o = spec_q[rdd_idx_i];

  for (genvar t = 0; t < NT; t++) begin : g_old
    assign cmt_old_o[t] = arch_q[{TID_W'(t), cmt_areg_i[t]}];
  end

  always_comb begin
    arch_d = arch_q;
    for (int t = 0; t < NT; t++) begin
      if (cmt_en_i[t]) arch_d[{TID_W'(t), cmt_areg_i[t]}] = cmt_tag_i[t];
    end
    spec_d = spec_q;
    if (wr_en_i) spec_d[wr_idx_i] = wr_tag_i;
    // flush sees this cycle's commit
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < NA; a++) begin
        if (flush_i[t]) spec_d[t*NA+a] = arch_d[t*NA+a];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NE; i++) begin
        spec_q[i] <= PREG_W'(i);
        arch_q[i] <= PREG_W'(i);
      end
    end else begin
      spec_q <= spec_d;
      arch_q <= arch_d;
    end
  end
endmodule

// File: rtl/mt_rename_top.sv
module mt_rename_top
  import mt_rename_pkg::*;
#(
  parameter int unsigned NT = RN_THREADS,
  parameter int unsigned NA = RN_AREGS,
  parameter int unsigned NP = RN_PREGS,
  localparam int unsigned TID_W  = $clog2(NT),
  localparam int unsigned AREG_W = $clog2(NA),
  localparam int unsigned PREG_W = $clog2(NP)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ren_valid_i,
  input  logic [TID_W-1:0]          ren_tid_i,
  input  logic [AREG_W-1:0]         ren_src0_i,
  input  logic [AREG_W-1:0]         ren_src1_i,
  input  logic [AREG_W-1:0]         ren_dst_i,
  output logic                      ren_ready_o,
  output logic [PREG_W-1:0]         src0_tag_o,
  output logic [PREG_W-1:0]         src1_tag_o,
  output logic [PREG_W-1:0]         dst_tag_o,
  output logic [PREG_W-1:0]         old_tag_o,
  input  logic [NT-1:0]             cmt_valid_i,
  input  logic [NT-1:0][AREG_W-1:0] cmt_areg_i,
  input  logic [NT-1:0][PREG_W-1:0] cmt_tag_i,
  input  logic [NT-1:0]             flush_i
);
  logic                      fl_avail, fire;
  logic [PREG_W-1:0]         alloc_tag;
  logic [NP-1:0]             release_vec, free_vec;
  logic [NT-1:0][NP-1:0]     rel_thr;
  logic [NT-1:0][PREG_W-1:0] cmt_old;

  assign ren_ready_o = fl_avail && !flush_i[ren_tid_i];
  assign fire        = ren_valid_i && ren_ready_o;
  assign dst_tag_o   = alloc_tag;

  mt_free_list #(.NP(NP), .NRES(NT * NA)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (fire),
    .avail_o    (fl_avail),
    .alloc_tag_o(alloc_tag),
    .release_i  (release_vec),
    .free_o     (free_vec)
  );

  mt_map_table #(.NT(NT), .NA(NA), .NP(NP)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd0_idx_i ({ren_tid_i, ren_src0_i}),
    .rd1_idx_i ({ren_tid_i, ren_src1_i}),
    .rdd_idx_i ({ren_tid_i, ren_dst_i}),
    .rd0_tag_o (src0_tag_o),
    .rd1_tag_o (src1_tag_o),
    .rdd_tag_o (old_tag_o),
    .wr_en_i   (fire),
    .wr_idx_i  ({ren_tid_i, ren_dst_i}),
    .wr_tag_i  (alloc_tag),
    .cmt_en_i  (cmt_valid_i),
    .cmt_areg_i(cmt_areg_i),
    .cmt_tag_i (cmt_tag_i),
    .cmt_old_o (cmt_old),
    .flush_i   (flush_i)
  );

  // per-thread record of tags allocated but not yet committed
  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic [NP-1:0] own_q, cmt_oh, new_oh, old_oh;
    assign cmt_oh = cmt_valid_i[t] ? (NP'(1) << cmt_tag_i[t]) : '0;
    assign old_oh = cmt_valid_i[t] ? (NP'(1) << cmt_old[t]) : '0;
    assign new_oh = (fire && ren_tid_i == TID_W'(t)) ? (NP'(1) << alloc_tag) : '0;
    assign rel_thr[t] = old_oh | (flush_i[t] ? (own_q & ~cmt_oh) : '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         own_q <= '0;
      else if (flush_i[t]) own_q <= '0;
      else                 own_q <= (own_q & ~cmt_oh) | new_oh;
    end
  end

  always_comb begin
    release_vec = '0;
    for (int t = 0; t < NT; t++) release_vec |= rel_thr[t];
  end
endmodule

// File: rtl/mt_rename_chk.sv
module mt_rename_chk #(
  parameter int unsigned NT = 2,
  parameter int unsigned NP = 32,
  localparam int unsigned TID_W  = $clog2(NT),
  localparam int unsigned PREG_W = $clog2(NP)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ren_valid_i,
  input logic                      ren_ready_o,
  input logic [PREG_W-1:0]         dst_tag_o,
  input logic [PREG_W-1:0]         old_tag_o,
  input logic [NT-1:0]             cmt_valid_i,
  input logic [NT-1:0]             flush_i,
  input logic [NT-1:0][PREG_W-1:0] cmt_old,
  input logic [NP-1:0]             free_vec
);
  p_new_tag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o) |-> (dst_tag_o != old_tag_o));

  p_alloc_consumed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && ren_ready_o) |=> !free_vec[$past(dst_tag_o)]);

  p_stall_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && !ren_ready_o && cmt_valid_i == '0 && flush_i == '0) |=> $stable(free_vec));

  for (genvar t = 0; t < NT; t++) begin : g_cmt
    p_commit_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_valid_i[t] |=> free_vec[$past(cmt_old[t])]);
  end
endmodule

bind mt_rename_top mt_rename_chk #(.NT(NT), .NP(NP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ren_valid_i(ren_valid_i),
  .ren_ready_o(ren_ready_o),
  .dst_tag_o  (dst_tag_o),
  .old_tag_o  (old_tag_o),
  .cmt_valid_i(cmt_valid_i),
  .flush_i    (flush_i),
  .cmt_old    (cmt_old),
  .free_vec   (free_vec)
);

// File: tb/mt_rename_top_tb_top.sv
`timescale 1ns/1ps
module mt_rename_top_tb_top;
  localparam int NT = 2;
  localparam int NA = 8;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic            ren_valid_i = 1'b0;
  logic [0:0]      ren_tid_i = '0;
  logic [2:0]      ren_src0_i = '0, ren_src1_i = '0, ren_dst_i = '0;
  logic            ren_ready_o;
  logic [4:0]      src0_tag_o, src1_tag_o, dst_tag_o, old_tag_o;
  logic [1:0]      cmt_valid_i = '0;
  logic [1:0][2:0] cmt_areg_i = '0;
  logic [1:0][4:0] cmt_tag_i = '0;
  logic [1:0]      flush_i = '0;

  mt_rename_top #(.NT(NT), .NA(NA), .NP(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid_i), .ren_tid_i(ren_tid_i),
    .ren_src0_i(ren_src0_i), .ren_src1_i(ren_src1_i), .ren_dst_i(ren_dst_i),
    .ren_ready_o(ren_ready_o),
    .src0_tag_o(src0_tag_o), .src1_tag_o(src1_tag_o),
    .dst_tag_o(dst_tag_o), .old_tag_o(old_tag_o),
    .cmt_valid_i(cmt_valid_i), .cmt_areg_i(cmt_areg_i),
    .cmt_tag_i(cmt_tag_i), .flush_i(flush_i)
  );

  typedef struct {
    bit    rdy;
    int    s0, s1, d, o;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  int        spec_m [NT][NA];
  int        arch_m [NT][NA];
  bit [NP-1:0] free_m;
  bit [NP-1:0] own_m [NT];

  function automatic void chk(string req, int act, int expv, string what);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endfunction

  task automatic step(input bit rv, input int tid, input int s0, input int s1, input int d,
                      input bit c0, input int ca0, input int cp0,
                      input bit c1, input int ca1, input int cp1,
                      input bit [1:0] fl, input string req);
    exp_t e;
    int   dsel;
    @(negedge clk);
    e.rdy = (free_m != '0) && !fl[tid];
    dsel = 0;
    for (int i = NP - 1; i >= 0; i--) if (free_m[i]) dsel = i;
    e.s0 = spec_m[tid][s0]; e.s1 = spec_m[tid][s1];
    e.d = dsel; e.o = spec_m[tid][d]; e.req = req;
    if (rv) exp_q.push_back(e);
    ren_valid_i = rv; ren_tid_i = 1'(tid);
    ren_src0_i = 3'(s0); ren_src1_i = 3'(s1); ren_dst_i = 3'(d);
    cmt_valid_i = {c1, c0};
    cmt_areg_i[0] = 3'(ca0); cmt_tag_i[0] = 5'(cp0);
    cmt_areg_i[1] = 3'(ca1); cmt_tag_i[1] = 5'(cp1);
    flush_i = fl;
    if (c0) begin free_m[arch_m[0][ca0]] = 1; arch_m[0][ca0] = cp0; own_m[0][cp0] = 0; end
    if (c1) begin free_m[arch_m[1][ca1]] = 1; arch_m[1][ca1] = cp1; own_m[1][cp1] = 0; end
    for (int t = 0; t < NT; t++) begin
      if (fl[t]) begin
        free_m |= own_m[t]; own_m[t] = '0;
        for (int a = 0; a < NA; a++) spec_m[t][a] = arch_m[t][a];
      end
    end
    if (rv && e.rdy) begin
      free_m[dsel] = 0; spec_m[tid][d] = dsel; own_m[tid][dsel] = 1;
    end
  endtask

  task automatic ren(input int tid, input int s0, input int s1, input int d, input string req);
    step(1, tid, s0, s1, d, 0, 0, 0, 0, 0, 0, 2'b00, req);
  endtask

  // monitor: pop expected item whenever a request is presented
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (rst_ni && ren_valid_i) begin
        if (exp_q.size() == 0) begin
          chk("R3", 1, 0, "unexpected request");
        end else begin
          e = exp_q.pop_front();
          chk(e.req, int'(ren_ready_o), int'(e.rdy), "ready");
          if (e.rdy) begin
            chk(e.req, int'(src0_tag_o), e.s0, "src0");
            chk(e.req, int'(src1_tag_o), e.s1, "src1");
            chk(e.req, int'(dst_tag_o), e.d, "dst");
            chk(e.req, int'(old_tag_o), e.o, "old");
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      own_m[t] = '0;
      for (int a = 0; a < NA; a++) begin spec_m[t][a] = t*NA + a; arch_m[t][a] = t*NA + a; end
    end
    for (int i = 0; i < NP; i++) free_m[i] = (i >= NT*NA);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R1", int'(ren_ready_o), 1, "ready after reset");

    ren(0, 1, 2, 3, "R1");            // 1,2,16,3
    ren(1, 1, 2, 3, "R1 R2");         // 9,10,17,11
    ren(0, 3, 3, 3, "R3 R4 R5");      // 16,16,18,16
    ren(1, 3, 7, 3, "R2 R3");         // 17,15,19,17
    // rename with a commit on the same thread (tag 16 committed, 3 freed)
    step(1, 0, 3, 5, 5, 1, 3, 16, 0, 0, 0, 2'b00, "R7");
    ren(1, 0, 0, 0, "R7");            // dst reuses freed tag 3
    // commit t0 while flushing t1 and renaming t0
    step(1, 0, 5, 3, 4, 1, 3, 18, 0, 0, 0, 2'b10, "R7 R9");
    ren(1, 3, 0, 1, "R8 R9");
    ren(0, 1, 2, 6, "R2");            // t0 untouched by t1 flush
    // commit and flush the same thread together
    step(0, 0, 0, 0, 0, 1, 4, spec_m[0][4], 0, 0, 0, 2'b01, "R10");
    ren(0, 4, 5, 3, "R10 R8");
    // rename into a thread being flushed is held off
    step(1, 1, 1, 2, 3, 0, 0, 0, 0, 0, 0, 2'b10, "R6");
    ren(1, 3, 1, 2, "R6 R8");
    // exhaust the pool
    for (int k = 0; k < 34; k++) ren(0, 1, 2, 6, "R6");
    ren(1, 2, 2, 2, "R6");
    step(0, 0, 0, 0, 0, 1, 6, spec_m[0][6], 0, 0, 0, 2'b00, "R7");
    ren(1, 6, 6, 6, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, "R9");
    ren(0, 6, 2, 7, "R8 R9");
    ren(1, 6, 3, 3, "R2 R3");
    ren(0, 7, 7, 7, "R3 R5");

    @(negedge clk);
    ren_valid_i = 0; cmt_valid_i = '0; flush_i = '0;
    repeat (3) @(negedge clk);
    chk("R3", exp_q.size(), 0, "pending items");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule